// File: doc/BRIEF.md
# PRBS Pattern Lane (Generator and Checker)

This block is one channel of a serial-link bit error rate tester. A transmit side produces a fresh 80-bit parallel word every clock cycle from a Fibonacci linear feedback shift register. The register length can be set to 7, 14 or 31 bits, and each channel loads its own seed, so neighbouring channels never carry the same stream in phase. The generator can also split the stream into repeating segments. Each segment is a run of alternating one/zero bits followed by a run of pseudo-random bits, and both run lengths are configurable.

The receive side rebuilds the expected stream from the same configuration and seed. It compares every received word bit by bit and adds the number of mismatching bits to a saturating error counter. A second counter tracks how many bits were compared. A lock flag reports whether the link is carrying the pattern cleanly. A one-cycle request flips one bit of the next transmitted word, so that a looped-back lane can show that each injected error is counted exactly once. All configuration is captured on a reseed pulse, which restarts both sides together.

Top module: `prbs_bert_lane`

## Requirements
- R1: After reset, tx_valid, err_cnt, bit_cnt and lock are all zero, and no word is produced until the first reseed pulse.
- R2: In each word, bit 0 is the earliest bit. Each random bit is the XOR of the register taps, and it is shifted into bit 0 of the register. The taps are set by len_sel: 00 gives x^7+x^6+1 (state bits 6,5); 01 gives x^14+x^13+x^12+x^2+1 (state bits 13,12,11,1); 10 and 11 give x^31+x^28+1 (state bits 30,27).
- R3: On reseed, the low L bits of seed become the register state. An all-zero value is replaced by 1, so the register never holds zero and streams from different seeds differ.
- R4: len_sel, seed, pat_en, alt_bits and rnd_bits take effect only when reseed is sampled high. At that edge tx_valid goes low. The first word of the new stream appears after the following edge, and tx_valid then stays high.
- R5: When pat_en is set and both alt_bits and rnd_bits are nonzero, the stream repeats two runs. The first is alt_bits alternating bits that start with 1. The second is rnd_bits register bits. The register state carries on across runs. Otherwise the stream is purely random.
- R6: When inj_req is high at an edge that produces a word, bit 0 of that word is inverted. No other bit changes.
- R7: At each edge with rx_valid high and reseed low, rx_word is compared with the rebuilt stream, which is seeded at the same reseed as the generator. err_cnt grows by the number of differing bits and bit_cnt grows by 80.
- R8: In loopback, each injection request raises err_cnt by exactly one.
- R9: lock rises at the edge that accepts the 64th consecutive word with zero errors.
- R10: lock falls at the edge that accepts the 8th consecutive word with more than 8 errors. A word with 1 to 8 errors resets both run counts. Reseed clears lock.
- R11: clr high at an edge zeroes both counters, and any word at that edge is not counted. Both counters saturate at all ones.
- R12: A word that arrives at the same edge as a reseed pulse is discarded, leaving both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reseed | input | 1 | Capture configuration and restart both sides |
| len_sel | input | 2 | Register length select (00:7, 01:14, 1x:31) |
| seed | input | 31 | Start state, low L bits used |
| pat_en | input | 1 | Enable alternating/random segment mode |
| alt_bits | input | 16 | Length of the alternating run in bits |
| rnd_bits | input | 16 | Length of the random run in bits |
| inj_req | input | 1 | Invert bit 0 of the word produced at this edge |
| tx_word | output | 80 | Generated word, bit 0 first |
| tx_valid | output | 1 | tx_word carries stream data |
| rx_word | input | 80 | Received word to check |
| rx_valid | input | 1 | rx_word is valid this cycle |
| clr | input | 1 | Synchronous clear of both counters |
| err_cnt | output | 64 | Saturating count of mismatched bits |
| bit_cnt | output | 64 | Saturating count of compared bits |
| lock | output | 1 | Checker is in step with a clean stream |

## Verification
The lane is looped back through a mask, and every cycle is compared against a behavioural model. The pure-random stream is run at all three lengths and under several seeds, including zero, so tap errors, wrong length masks and wrong bit ordering each show up as mismatches within a few words. Segment mode is run with runs shorter than a word and runs longer than a word, which separates errors in run-boundary handling from errors in register carry-over. Masks of 9 wrong bits for 7 words and then for 8 words probe the exact lock-loss boundary. Single injections show whether errors are lost or counted twice.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int LFSR_W = 31;
  localparam int SEG_W  = 16;

  typedef struct packed {
    logic [1:0]       len;
    logic             alt_on;
    logic [SEG_W-1:0] alt_len;
    logic [SEG_W-1:0] rnd_len;
  } mode_t;

  typedef struct packed {
    logic [LFSR_W-1:0] lfsr;
    logic              in_alt;
    logic              abit;
    logic [SEG_W-1:0]  rem;
  } gen_st_t;

  function automatic logic [LFSR_W-1:0] len_mask(logic [1:0] len);
    case (len)
      2'b00:   return LFSR_W'(32'h0000_007f);
      2'b01:   return LFSR_W'(32'h0000_3fff);
      default: return LFSR_W'(32'h7fff_ffff);
    endcase
  endfunction

  function automatic logic lfsr_fb(logic [1:0] len, logic [LFSR_W-1:0] s);
    case (len)
      2'b00:   return s[6] ^ s[5];
      2'b01:   return s[13] ^ s[12] ^ s[11] ^ s[1];
      default: return s[30] ^ s[27];
    endcase
  endfunction

  function automatic gen_st_t seed_state(logic [1:0] len, logic [SEG_W-1:0] alt_len,
                                         logic [LFSR_W-1:0] seed);
    gen_st_t st;
    st.lfsr = seed & len_mask(len);
    if (st.lfsr == '0) st.lfsr = LFSR_W'(1);
    st.in_alt = 1'b1;
    st.abit   = 1'b1;
    st.rem    = alt_len;
    return st;
  endfunction
endpackage

// File: rtl/pat_step.sv
module pat_step
  import prbs_pkg::*;
#(
  parameter int W = 80
) (
  input  mode_t       mode,
  input  gen_st_t     cur,
  output logic [W-1:0] word,
  output gen_st_t     nxt
);
  gen_st_t s;
  logic    fb;

  always_comb begin
    s    = cur;
    word = '0;
    fb   = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (mode.alt_on && s.in_alt) begin
        word[i] = s.abit;
        s.abit  = ~s.abit;
        s.rem   = s.rem - 1'b1;
        if (s.rem == '0) begin
          s.in_alt = 1'b0;
          s.rem    = mode.rnd_len;
        end
      end else begin
        fb      = lfsr_fb(mode.len, s.lfsr);
        s.lfsr  = {s.lfsr[LFSR_W-2:0], fb} & len_mask(mode.len);
        word[i] = fb;
        if (mode.alt_on) begin
          s.rem = s.rem - 1'b1;
          if (s.rem == '0) begin
            s.in_alt = 1'b1;
            s.abit   = 1'b1;
            s.rem    = mode.alt_len;
          end
        end
      end
    end
    nxt = s;
  end
endmodule

// File: rtl/pat_gen.sv
module pat_gen
  import prbs_pkg::*;
#(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reseed,
  input  gen_st_t      seed_st,
  input  mode_t        mode,
  input  logic         inj_req,
  output logic [W-1:0] tx_word,
  output logic         tx_valid
);
  gen_st_t      st, st_nxt;
  logic [W-1:0] g_word;
  logic         armed;

  pat_step #(.W(W)) u_step (.mode(mode), .cur(st), .word(g_word), .nxt(st_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= '0;
      armed    <= 1'b0;
      tx_word  <= '0;
      tx_valid <= 1'b0;
    end else if (reseed) begin
      st       <= seed_st;
      armed    <= 1'b1;
      tx_valid <= 1'b0;
    end else if (armed) begin
      st       <= st_nxt;
      tx_word  <= g_word ^ {{(W-1){1'b0}}, inj_req};
      tx_valid <= 1'b1;
    end
  end

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (st.lfsr != '0));
  // R4
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_valid) |-> $past(reseed));
endmodule

// File: rtl/pat_chk.sv
module pat_chk
  import prbs_pkg::*;
#(
  parameter int W      = 80,
  parameter int CNT_W  = 64,
  parameter int LOCK_N = 64,
  parameter int LOSS_N = 8,
  parameter int BAD_TH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reseed,
  input  logic             clr,
  input  gen_st_t          seed_st,
  input  mode_t            mode,
  input  logic [W-1:0]     rx_word,
  input  logic             rx_valid,
  output logic [CNT_W-1:0] err_cnt,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             lock
);
  localparam int PW     = $clog2(W + 1);
  localparam int GOOD_W = $clog2(LOCK_N + 1);
  localparam int BAD_W  = $clog2(LOSS_N + 1);

  gen_st_t           st, st_nxt;
  logic [W-1:0]      exp_word, diff;
  logic [PW-1:0]     pop;
  logic [CNT_W:0]    err_sum, bit_sum;
  logic [GOOD_W-1:0] good_run;
  logic [BAD_W-1:0]  bad_run;
  logic              take;

  pat_step #(.W(W)) u_step (.mode(mode), .cur(st), .word(exp_word), .nxt(st_nxt));

  assign diff = rx_word ^ exp_word;
  assign take = rx_valid && !reseed;

  always_comb begin
    pop = '0;
    for (int i = 0; i < W; i++) pop = pop + PW'(diff[i]);
  end

  assign err_sum = {1'b0, err_cnt} + (CNT_W+1)'(pop);
  assign bit_sum = {1'b0, bit_cnt} + (CNT_W+1)'(W);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else if (reseed) begin
      st <= seed_st;
    end else if (rx_valid) begin
      st <= st_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err_cnt <= '0;
      bit_cnt <= '0;
    end else if (take) begin
      err_cnt <= err_sum[CNT_W] ? '1 : err_sum[CNT_W-1:0];
      bit_cnt <= bit_sum[CNT_W] ? '1 : bit_sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || reseed) begin
      lock     <= 1'b0;
      good_run <= '0;
      bad_run  <= '0;
    end else if (rx_valid) begin
      if (pop == '0) begin
        bad_run <= '0;
        if (good_run != GOOD_W'(LOCK_N)) good_run <= good_run + 1'b1;
        if (good_run == GOOD_W'(LOCK_N - 1)) lock <= 1'b1;
      end else if (pop > PW'(BAD_TH)) begin
        good_run <= '0;
        if (bad_run != BAD_W'(LOSS_N)) bad_run <= bad_run + 1'b1;
        if (bad_run == BAD_W'(LOSS_N - 1)) lock <= 1'b0;
      end else begin
        good_run <= '0;
        bad_run  <= '0;
      end
    end
  end

  // R7
  bits_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!take && !clr) |=> $stable(bit_cnt));
  // R11
  err_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> err_cnt >= $past(err_cnt));
  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(rx_valid) && !$past(reseed));
  // R12
  reseed_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    reseed |=> !lock);
endmodule

// File: rtl/prbs_bert_lane.sv
module prbs_bert_lane
  import prbs_pkg::*;
#(
  parameter int W      = 80,
  parameter int CNT_W  = 64,
  parameter int LOCK_N = 64,
  parameter int LOSS_N = 8,
  parameter int BAD_TH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reseed,
  input  logic [1:0]        len_sel,
  input  logic [LFSR_W-1:0] seed,
  input  logic              pat_en,
  input  logic [SEG_W-1:0]  alt_bits,
  input  logic [SEG_W-1:0]  rnd_bits,
  input  logic              inj_req,
  output logic [W-1:0]      tx_word,
  output logic              tx_valid,
  input  logic [W-1:0]      rx_word,
  input  logic              rx_valid,
  input  logic              clr,
  output logic [CNT_W-1:0]  err_cnt,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              lock
);
  mode_t   mode_q, mode_in;
  gen_st_t seed_st;

  always_comb begin
    mode_in.len     = len_sel;
    mode_in.alt_on  = pat_en && (alt_bits != '0) && (rnd_bits != '0);
    mode_in.alt_len = alt_bits;
    mode_in.rnd_len = rnd_bits;
  end

  assign seed_st = seed_state(len_sel, alt_bits, seed);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (reseed) mode_q <= mode_in;
  end

  pat_gen #(.W(W)) u_gen (
    .clk(clk), .rst(rst), .reseed(reseed), .seed_st(seed_st), .mode(mode_q),
    .inj_req(inj_req), .tx_word(tx_word), .tx_valid(tx_valid)
  );

  pat_chk #(.W(W), .CNT_W(CNT_W), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N), .BAD_TH(BAD_TH)) u_chk (
    .clk(clk), .rst(rst), .reseed(reseed), .clr(clr), .seed_st(seed_st), .mode(mode_q),
    .rx_word(rx_word), .rx_valid(rx_valid), .err_cnt(err_cnt), .bit_cnt(bit_cnt), .lock(lock)
  );

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reseed |=> $stable(mode_q));
endmodule

// File: tb/sim_prbs_bert_lane.sv
module sim_prbs_bert_lane;
  localparam int CLK_P = 10;
  localparam int W     = 80;

  logic         clk = 1'b0, rst = 1'b1, reseed = 1'b0, pat_en = 1'b0;
  logic         inj_req = 1'b0, clr = 1'b0, running = 1'b0, done = 1'b0;
  logic [1:0]   len_sel = 2'b00;
  logic [30:0]  seed = '0;
  logic [15:0]  alt_bits = '0, rnd_bits = '0;
  logic [W-1:0] flip = '0;
  logic [W-1:0] tx_word, rx_word;
  logic         tx_valid, lock;
  logic [63:0]  err_cnt, bit_cnt;
  int           checks = 0, errors = 0;
  string        ph = "R2";

  assign rx_word = tx_word ^ flip;

  prbs_bert_lane u0 (
    .clk(clk), .rst(rst), .reseed(reseed), .len_sel(len_sel), .seed(seed), .pat_en(pat_en),
    .alt_bits(alt_bits), .rnd_bits(rnd_bits), .inj_req(inj_req), .tx_word(tx_word),
    .tx_valid(tx_valid), .rx_word(rx_word), .rx_valid(tx_valid), .clr(clr),
    .err_cnt(err_cnt), .bit_cnt(bit_cnt), .lock(lock)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference: index 0 transmit side, index 1 receive side
  logic [30:0]  m_s [2];
  logic         m_alt [2], m_ab [2];
  int           m_rem [2];
  logic [1:0]   c_len = 2'b00;
  bit           c_alt_on = 1'b0;
  int           c_alen = 0, c_rlen = 0;
  logic [W-1:0] m_tx = '0, m_raw = '0, m_exp = '0;
  bit           m_valid = 1'b0, m_armed = 1'b0, m_lock = 1'b0;
  logic [63:0]  m_err = '0, m_bits = '0;
  int           m_good = 0, m_bad = 0, m_pop = 0;

  function automatic logic [30:0] b_mask(logic [1:0] l);
    int n = (l == 2'b00) ? 7 : (l == 2'b01) ? 14 : 31;
    return 31'((64'd1 << n) - 1);
  endfunction

  task automatic m_step(input int k, output logic [W-1:0] w);
    logic fb;
    w = '0;
    for (int i = 0; i < W; i++) begin
      if (c_alt_on && m_alt[k]) begin
        w[i] = m_ab[k];
        m_ab[k] = ~m_ab[k];
        m_rem[k]--;
        if (m_rem[k] == 0) begin m_alt[k] = 1'b0; m_rem[k] = c_rlen; end
      end else begin
        case (c_len)
          2'b00:   fb = m_s[k][6] ^ m_s[k][5];
          2'b01:   fb = m_s[k][13] ^ m_s[k][12] ^ m_s[k][11] ^ m_s[k][1];
          default: fb = m_s[k][30] ^ m_s[k][27];
        endcase
        m_s[k] = {m_s[k][29:0], fb} & b_mask(c_len);
        w[i] = fb;
        if (c_alt_on) begin
          m_rem[k]--;
          if (m_rem[k] == 0) begin m_alt[k] = 1'b1; m_ab[k] = 1'b1; m_rem[k] = c_alen; end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_tx = '0; m_valid = 0; m_armed = 0; m_err = '0; m_bits = '0;
      m_lock = 0; m_good = 0; m_bad = 0;
    end else if (reseed) begin
      c_len = len_sel;
      c_alt_on = pat_en && alt_bits != 0 && rnd_bits != 0;
      c_alen = int'(alt_bits);
      c_rlen = int'(rnd_bits);
      for (int k = 0; k < 2; k++) begin
        m_s[k] = seed & b_mask(len_sel);
        if (m_s[k] == 0) m_s[k] = 31'd1;
        m_alt[k] = 1'b1; m_ab[k] = 1'b1; m_rem[k] = c_alen;
      end
      m_lock = 0; m_good = 0; m_bad = 0;
      if (clr) begin m_err = '0; m_bits = '0; end
      m_valid = 0; m_armed = 1;
    end else begin
      if (m_valid) begin
        m_step(1, m_exp);
        m_pop = $countones((m_tx ^ flip) ^ m_exp);
        if (clr) begin m_err = '0; m_bits = '0; end
        else begin m_err += 64'(m_pop); m_bits += 64'(W); end
        if (m_pop == 0) begin
          m_bad = 0; m_good++;
          if (m_good >= 64) m_lock = 1;
        end else if (m_pop > 8) begin
          m_good = 0; m_bad++;
          if (m_bad >= 8) m_lock = 0;
        end else begin
          m_good = 0; m_bad = 0;
        end
      end else if (clr) begin
        m_err = '0; m_bits = '0;
      end
      if (m_armed) begin
        m_step(0, m_raw);
        m_tx = m_raw ^ {{(W-1){1'b0}}, inj_req};
        m_valid = 1;
      end
    end
  end

  task automatic chk(input string tag, input bit ok, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && !rst) begin
      chk(ph,   tx_word == m_tx, tx_word, m_tx);
      chk("R4", tx_valid == m_valid, W'(tx_valid), W'(m_valid));
      chk("R7", err_cnt == m_err, W'(err_cnt), W'(m_err));
      chk("R7", bit_cnt == m_bits, W'(bit_cnt), W'(m_bits));
      chk("R9", lock == m_lock, W'(lock), W'(m_lock));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reseed(input logic [1:0] l, input logic [30:0] sd, input logic pe,
                           input logic [15:0] a, input logic [15:0] r);
    len_sel = l; seed = sd; pat_en = pe; alt_bits = a; rnd_bits = r;
    reseed = 1'b1;
    @(negedge clk);
    reseed = 1'b0;
  endtask

  task automatic inject_once();
    logic [63:0] e0;
    e0 = err_cnt;
    inj_req = 1'b1;
    @(negedge clk);
    inj_req = 1'b0;
    chk("R6", tx_word == (m_raw ^ W'(1)), tx_word, m_raw ^ W'(1));
    @(negedge clk);
    chk("R8", err_cnt == e0 + 1, W'(err_cnt), W'(e0 + 1));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w1, w2;
    logic [63:0]  b0;
    cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", tx_valid == 0, W'(tx_valid), '0);
    chk("R1", err_cnt == 0 && bit_cnt == 0, W'(err_cnt | bit_cnt), '0);
    chk("R1", lock == 0, W'(lock), '0);
    running = 1'b1;
    cyc(3);
    chk("R1", tx_valid == 0, W'(tx_valid), '0);

    // R2 R9: pure 7-bit stream, lock acquisition
    ph = "R2";
    do_reseed(2'b00, 31'h5A, 1'b0, 16'd0, 16'd0);
    cyc(66);
    chk("R9", lock == 1, W'(lock), W'(1));

    // R6 R8: injection counted once each
    inject_once();
    cyc(2);
    inject_once();
    cyc(2);

    // R10: 7 bad words keep lock, 8 drop it
    flip = W'(9'h1ff);
    cyc(7);
    chk("R10", lock == 1, W'(lock), W'(1));
    flip = '0;
    cyc(1);
    flip = W'(9'h1ff);
    cyc(8);
    chk("R10", lock == 0, W'(lock), '0);
    flip = '0;
    cyc(3);

    // R11: synchronous clear
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R11", err_cnt == 0 && bit_cnt == 0, W'(err_cnt | bit_cnt), '0);
    cyc(2);

    // R2: other lengths
    do_reseed(2'b01, 31'h1234, 1'b0, 16'd0, 16'd0);
    cyc(20);
    do_reseed(2'b10, 31'h7ABCDEF0, 1'b0, 16'd0, 16'd0);
    cyc(20);
    do_reseed(2'b11, 31'h00C0FFEE, 1'b0, 16'd0, 16'd0);
    cyc(10);

    // R3: zero seed and distinct seeds
    ph = "R3";
    do_reseed(2'b00, 31'h0, 1'b0, 16'd0, 16'd0);
    cyc(1);
    chk("R3", tx_word != 0, tx_word, '1);
    cyc(5);
    do_reseed(2'b10, 31'h11111, 1'b0, 16'd0, 16'd0);
    cyc(1);
    w1 = tx_word;
    do_reseed(2'b10, 31'h22222, 1'b0, 16'd0, 16'd0);
    cyc(1);
    w2 = tx_word;
    chk("R3", w1 != w2, w2, ~w1);

    // R5: segment mode, short and long runs
    ph = "R5";
    do_reseed(2'b00, 31'h33, 1'b1, 16'd5, 16'd20);
    cyc(30);
    do_reseed(2'b01, 31'h2A5, 1'b1, 16'd90, 16'd33);
    cyc(30);
    do_reseed(2'b10, 31'h999, 1'b1, 16'd0, 16'd40);
    cyc(10);

    // R4: inputs change without reseed
    ph = "R4";
    len_sel = 2'b00; seed = 31'h7; pat_en = 1'b1; alt_bits = 16'd3; rnd_bits = 16'd3;
    cyc(10);
    do_reseed(2'b00, 31'h41, 1'b0, 16'd0, 16'd0);
    cyc(70);
    chk("R9", lock == 1, W'(lock), W'(1));

    // R12: word at a reseed edge is discarded
    ph = "R12";
    b0 = bit_cnt;
    do_reseed(2'b01, 31'h77, 1'b0, 16'd0, 16'd0);
    chk("R12", bit_cnt == b0, W'(bit_cnt), W'(b0));
    chk("R12", lock == 0, W'(lock), '0);
    cyc(5);

    running = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule